// File: doc/BRIEF.md
# Cascaded Multipath Replica-Cancellation Stage

This block is the sample path of a multi-loop code tracker that strips a delayed multipath copy from the incoming signal before the final tracking loop sees it. Each input sample is split into several branch feeds. The first branch receives the raw sample. Each cancellation stage `k` subtracts from that same raw sample the local replica chip of tracking branch `k` scaled by that branch's amplitude weight. Stage 0 produces the feed for the branch that follows the multipath copy. The last stage produces the feed for the navigation branch, whose replica is used for ranging. More paths are handled by raising the `NSTAGE` parameter.

The replicas are single-bit ±1 chips. Each weighted subtraction is therefore an add or a subtract of a signed weight, and the result saturates to the sample width. A path-count estimate and a threshold, both supplied from outside, decide whether the cascade is active. That decision is taken only on a code-epoch sample, so integrations downstream never see a mid-period change. While the cascade is inactive, every stage passes the raw sample through unchanged.

Top module: `cnc_cascade`

## Requirements
- R1: While reset is held, `out_valid`, `casc_active`, `raw_out` and every stage output are zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `raw_out`, `stage_out` and `casc_active` keep their values.
- R3: One clock after a valid sample, `raw_out` equals that sample.
- R4: Replica encoding: chip bit 1 stands for +1 and chip bit 0 stands for −1. When active, stage 0 outputs `in_sample − w0·c0`, where `w0` is `weight[WW-1:0]` and `c0` is `chip[0]`.
- R5: When active, the last stage (the navigation feed) outputs `in_sample − w1·c1` from the raw sample, not from the stage 0 result. Here `w1` is `weight[2*WW-1:WW]` and `c1` is `chip[1]`.
- R6: Stage results are clamped to the range −32768 to +32767 (the default 16-bit width).
- R7: The cascade becomes active when `path_cnt >= path_thr` (unsigned). This is evaluated only on a sample with `in_valid` and `epoch` both high, and the decision applies from that sample on. An `epoch` pulse without `in_valid` does nothing.
- R8: Changes to `path_cnt` or `path_thr` on samples without `epoch` have no effect.
- R9: When the cascade is inactive, every stage output equals the raw sample, whatever the chips and weights are.
- R10: `casc_active` shows the cascade decision that was applied to the sample currently on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Filtered input sample, signed |
| epoch | input | 1 | Code-epoch boundary marker on this sample |
| path_cnt | input | CW | Estimated number of arriving paths |
| path_thr | input | CW | Path-count threshold for enabling the cascade |
| chip | input | NSTAGE | Replica chip per stage, 1 = +1, 0 = −1 |
| weight | input | NSTAGE*WW | Signed amplitude weight per stage, stage 0 in the low bits |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| raw_out | output | DW | Registered raw sample (first-branch feed) |
| stage_out | output | NSTAGE*DW | Registered stage results, stage 0 low, navigation feed high |
| casc_active | output | 1 | Cascade decision applied to the current outputs |

## Verification
A corrupted enable register shows up on the very next valid sample. The stage outputs stop matching `raw_out` while `casc_active` is low, or they fail to include the weighted chips while it is high. A wrong sign or a wrong replica choice in a stage shows up within one clock as a result that is off by twice the weight. A stage wrongly chained onto the previous stage's result shows up as an extra term on the navigation feed. Saturation faults are exposed only by samples near full scale, so the vectors drive both rails with the largest weights of both signs.

// File: rtl/cnc_pkg.sv
package cnc_pkg;
  typedef enum logic {
    CASC_OFF = 1'b0,
    CASC_ON  = 1'b1
  } casc_state_e;
endpackage

// File: rtl/cnc_epoch_gate.sv
// Holds the cascade on/off decision; it is re-evaluated only on epoch samples.
module cnc_epoch_gate #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          epoch,
  input  logic [CW-1:0] path_cnt,
  input  logic [CW-1:0] path_thr,
  output logic          en_now
);
  import cnc_pkg::*;

  casc_state_e state_q, state_d;
  logic        upd_en;
  logic        cmp_on;

  assign upd_en = in_valid & epoch;
  assign cmp_on = (path_cnt >= path_thr);

  always_comb begin
    state_d = state_q;
    if (upd_en) state_d = cmp_on ? CASC_ON : CASC_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= CASC_OFF;
    else if (upd_en) state_q <= state_d;
  end

  // The decision taken on an epoch sample applies to that same sample.
  assign en_now = (state_d == CASC_ON);
endmodule

// File: rtl/cnc_sub_stage.sv
// One weighted replica subtraction with saturation (combinational).
module cnc_sub_stage #(
  parameter int DW = 16,
  parameter int WW = 12
) (
  input  logic [DW-1:0] sample,
  input  logic          chip,
  input  logic [WW-1:0] weight,
  input  logic          active,
  output logic [DW-1:0] result
);
  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] MAXV = EW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [EW-1:0] MINV = -MAXV - EW'(1);

  logic signed [EW-1:0] s_ext, w_ext, contrib, diff;

  always_comb begin
    s_ext = {{(EW-DW){sample[DW-1]}}, sample};
    w_ext = {{(EW-WW){weight[WW-1]}}, weight};
    if (!active)   contrib = '0;
    else if (chip) contrib = w_ext;
    else           contrib = -w_ext;
    diff = s_ext - contrib;
    if (diff > MAXV)      result = MAXV[DW-1:0];
    else if (diff < MINV) result = MINV[DW-1:0];
    else                  result = diff[DW-1:0];
  end
endmodule

// File: rtl/cnc_cascade.sv
module cnc_cascade #(
  parameter int DW     = 16,
  parameter int WW     = 12,
  parameter int CW     = 4,
  parameter int NSTAGE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_sample,
  input  logic                 epoch,
  input  logic [CW-1:0]        path_cnt,
  input  logic [CW-1:0]        path_thr,
  input  logic [NSTAGE-1:0]    chip,
  input  logic [NSTAGE*WW-1:0] weight,
  output logic                 out_valid,
  output logic [DW-1:0]        raw_out,
  output logic [NSTAGE*DW-1:0] stage_out,
  output logic                 casc_active
);
  localparam int SOW = NSTAGE * DW;

  logic           en_now;
  logic [SOW-1:0] stage_d, stage_q;
  logic [DW-1:0]  raw_d, raw_q;
  logic           act_d, act_q, vld_q;

  cnc_epoch_gate #(.CW(CW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .epoch    (epoch),
    .path_cnt (path_cnt),
    .path_thr (path_thr),
    .en_now   (en_now)
  );

  // Each stage subtracts from the raw sample, never from a previous stage.
  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    cnc_sub_stage #(.DW(DW), .WW(WW)) u_sub (
      .sample (in_sample),
      .chip   (chip[k]),
      .weight (weight[k*WW +: WW]),
      .active (en_now),
      .result (stage_d[k*DW +: DW])
    );
  end

  always_comb begin
    raw_d = in_sample;
    act_d = en_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      stage_q <= '0;
      act_q   <= 1'b0;
    end else if (in_valid) begin
      raw_q   <= raw_d;
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign out_valid   = vld_q;
  assign raw_out     = raw_q;
  assign stage_out   = stage_q;
  assign casc_active = act_q;
endmodule

// File: rtl/cnc_cascade_chk.sv
module cnc_cascade_chk #(
  parameter int DW     = 16,
  parameter int WW     = 12,
  parameter int CW     = 4,
  parameter int NSTAGE = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [DW-1:0]        in_sample,
  input logic                 epoch,
  input logic [CW-1:0]        path_cnt,
  input logic [CW-1:0]        path_thr,
  input logic                 out_valid,
  input logic [DW-1:0]        raw_out,
  input logic [NSTAGE*DW-1:0] stage_out,
  input logic                 casc_active
);
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(raw_out) && $stable(stage_out)));
  assert_raw_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> raw_out == $past(in_sample));
  assert_epoch_decide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && epoch) |=> casc_active == ($past(path_cnt) >= $past(path_thr)));
  assert_no_midepoch_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && epoch) |=> $stable(casc_active));

  for (genvar k = 0; k < NSTAGE; k++) begin : g_bypass
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !casc_active) |-> stage_out[k*DW +: DW] == raw_out);
  end
endmodule

bind cnc_cascade cnc_cascade_chk #(
  .DW(DW), .WW(WW), .CW(CW), .NSTAGE(NSTAGE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sample   (in_sample),
  .epoch       (epoch),
  .path_cnt    (path_cnt),
  .path_thr    (path_thr),
  .out_valid   (out_valid),
  .raw_out     (raw_out),
  .stage_out   (stage_out),
  .casc_active (casc_active)
);

// File: tb/cnc_cascade_test.sv
module cnc_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        epoch = 1'b0;
  logic [3:0]  path_cnt = '0;
  logic [3:0]  path_thr = '0;
  logic [1:0]  chip = '0;
  logic [23:0] weight = '0;
  logic        out_valid;
  logic [15:0] raw_out;
  logic [31:0] stage_out;
  logic        casc_active;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cnc_cascade uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .epoch(epoch), .path_cnt(path_cnt), .path_thr(path_thr), .chip(chip),
    .weight(weight), .out_valid(out_valid), .raw_out(raw_out),
    .stage_out(stage_out), .casc_active(casc_active)
  );

  typedef struct packed {
    logic [15:0] s;
    logic        ep;
    logic [3:0]  cnt;
    logic [3:0]  thr;
    logic [1:0]  chp;
    logic [11:0] w0;
    logic [11:0] w1;
    logic [15:0] r1;
    logic [15:0] nav;
    logic        act;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{16'd1000,  1'b1, 4'd2,  4'd2, 2'b11, 12'd100,  12'd50,  16'd900,   16'd950,   1'b1},
    '{16'd1000,  1'b0, 4'd2,  4'd2, 2'b00, 12'd100,  12'd50,  16'd1100,  16'd1050,  1'b1},
    '{-16'sd500, 1'b0, 4'd0,  4'd2, 2'b01, -12'sd200,12'd300, -16'sd300, -16'sd200, 1'b1},
    '{16'd32700, 1'b0, 4'd0,  4'd2, 2'b00, 12'd2047, 12'h800, 16'h7FFF,  16'd30652, 1'b1},
    '{-16'sd32700,1'b0,4'd0,  4'd2, 2'b11, 12'd2047, 12'h800, 16'h8000, -16'sd30652, 1'b1},
    '{16'd1234,  1'b1, 4'd1,  4'd2, 2'b11, 12'd500,  12'd500, 16'd1234,  16'd1234,  1'b0},
    '{-16'sd77,  1'b0, 4'd5,  4'd2, 2'b00, 12'd2047, 12'd2047,-16'sd77,  -16'sd77,  1'b0},
    '{16'd10,    1'b1, 4'd3,  4'd3, 2'b10, 12'd7,    12'd9,   16'd17,    16'd1,     1'b1},
    '{16'h8000,  1'b0, 4'd3,  4'd3, 2'b00, 12'h800,  12'd1,   16'h8000,  -16'sd32767,1'b1},
    '{16'd0,     1'b1, 4'd15, 4'd0, 2'b11, -12'sd1,  12'd1,   16'd1,     -16'sd1,   1'b1},
    '{16'd5,     1'b1, 4'd0,  4'd1, 2'b11, 12'd9,    12'd9,   16'd5,     16'd5,     1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic drive(input logic [15:0] s, input logic ep, input logic [3:0] cnt,
                       input logic [3:0] thr, input logic [1:0] chp,
                       input logic [11:0] w0, input logic [11:0] w1);
    in_valid  = 1'b1;
    in_sample = s;
    epoch     = ep;
    path_cnt  = cnt;
    path_thr  = thr;
    chip      = chp;
    weight    = {w1, w0};
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 stage_out", stage_out, 32'd0);
    chk("R1 raw_out", {16'd0, raw_out}, 32'd0);
    chk("R1 casc_active", {31'd0, casc_active}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk (R3..R10)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].s, VEC[i].ep, VEC[i].cnt, VEC[i].thr, VEC[i].chp, VEC[i].w0, VEC[i].w1);
      @(negedge clk);
      chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
      chk("R3 raw_out", {16'd0, raw_out}, {16'd0, VEC[i].s});
      chk("R4 R6 R9 stage0", {16'd0, stage_out[15:0]}, {16'd0, VEC[i].r1});
      chk("R5 R6 R9 nav", {16'd0, stage_out[31:16]}, {16'd0, VEC[i].nav});
      chk("R7 R8 R10 casc_active", {31'd0, casc_active}, {31'd0, VEC[i].act});
    end

    // R2: idle samples hold outputs
    in_valid = 1'b0;
    in_sample = 16'd999;
    weight = '0;
    @(negedge clk);
    chk("R2 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R2 idle raw hold", {16'd0, raw_out}, 32'd5);
    chk("R2 idle stage hold", stage_out, {16'd5, 16'd5});

    // R7: epoch without in_valid is ignored
    epoch = 1'b1;
    path_cnt = 4'd9;
    path_thr = 4'd1;
    @(negedge clk);
    drive(16'd40, 1'b0, 4'd9, 4'd1, 2'b11, 12'd3, 12'd4);
    @(negedge clk);
    chk("R7 epoch needs valid active", {31'd0, casc_active}, 32'd0);
    chk("R9 bypass stage0", {16'd0, stage_out[15:0]}, 32'd40);
    chk("R9 bypass nav", {16'd0, stage_out[31:16]}, 32'd40);

    // R7: epoch with valid turns it on for that same sample
    drive(16'd40, 1'b1, 4'd9, 4'd1, 2'b11, 12'd3, 12'd4);
    @(negedge clk);
    chk("R7 epoch on", {31'd0, casc_active}, 32'd1);
    chk("R4 stage0 after epoch", {16'd0, stage_out[15:0]}, 32'd37);
    chk("R5 nav after epoch", {16'd0, stage_out[31:16]}, 32'd36);

    // R1: reset during operation
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset stage", stage_out, 32'd0);
    chk("R1 mid reset active", {31'd0, casc_active}, 32'd0);
    chk("R1 mid reset valid", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule